// File: doc/BRIEF.md
# Capture/Compare Interrupt Aggregation Unit

This unit gathers every interrupt source of a four-channel capture/compare timer block into two 8-bit pending registers. It drives a single interrupt request from those registers and two 8-bit mask registers. Each channel works in one of two modes. In compare mode, a match pulse raises the channel's pending bit. In capture mode, an event timestamp enters a one-deep buffer and then moves into the channel's time register, and the pending bit is raised at that move. Two timer-overflow pulses also raise pending bits of their own.

A capture event that arrives while the buffer is still occupied is an overrun, and the new timestamp is dropped. Overruns are combined in pairs into two shared pending bits. Each channel's overrun passes only if its own enable bit is set in a separate overrun-enable register, whose odd bits are reserved. Masks only gate the request line. Pending bits set whether or not they are masked, so software can poll for them. Software clears pending bits by writing zeros over a small register bus.

Top module: `ccu_irq_agg`

## Requirements
- R1: After reset, both pending registers and both mask registers read 0x00, the overrun-enable register reads 0xAA, every time register reads 0, and `irq_o` is low.
- R2: With `cap_mode_i[c]`=0 (compare mode), a `cmp_match_i[c]` pulse sets pending-0 bit c at the clock edge that samples it. This happens whatever the masks hold. In this mode a capture event leaves the pending bits and the time register unchanged.
- R3: A pulse on `tmr_ovf_i[0]` sets pending-0 bit 4, and a pulse on `tmr_ovf_i[1]` sets pending-0 bit 5.
- R4: With `cap_mode_i[c]`=1, a capture event fills channel c's buffer at the sampling edge. If the time register (address 8+c) is empty, the value moves into it on the next edge, and pending-0 bit c is set on that move, not when the buffer fills.
- R5: A bus read of time register 8+c with `rd_en_i`=1 returns the held value. If the buffer is full, the buffered value moves into the time register at that edge and sets pending-0 bit c again. If the buffer is empty, the time register is marked empty, so the next capture passes through one edge after entering the buffer.
- R6: A capture event is an overrun when the buffer is full and not being emptied at that edge. The new timestamp is dropped and the buffered value is kept.
- R7: The overruns of channels 0 and 1 set pending-1 bit 4, and those of channels 2 and 3 set pending-1 bit 5. A channel's overrun counts only if bit 2·c of the overrun-enable register is set.
- R8: The overrun-enable register (address 4) stores bits 0, 2, 4 and 6. Writes to bits 1, 3, 5 and 7 are ignored, and those bits always read 1.
- R9: A write to pending-0 (address 0) or pending-1 (address 1) clears the bits written as 0 and keeps the bits written as 1. A source that sets a bit in the same cycle wins over the clear.
- R10: `irq_o` is high exactly when some pending bit is set together with the same bit of its mask register. Pending-0 pairs with mask-0 (address 2), and pending-1 pairs with mask-1 (address 3).
- R11: Pending-0 bits 7:6 and all pending-1 bits other than 4 and 5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cap_mode_i | input | 4 | Per-channel mode: 1 capture, 0 compare |
| cap_evt_i | input | 4 | Per-channel capture event pulse |
| cap_ts_i | input | 4x16 | Per-channel timestamp taken with the event |
| cmp_match_i | input | 4 | Per-channel compare-match pulse |
| tmr_ovf_i | input | 2 | Timer overflow pulses |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (read side effects on time registers) |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 16 | Read data, combinational from address |
| pend0_o | output | 8 | Pending register 0 |
| pend1_o | output | 8 | Pending register 1 |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is an overrun. It needs the time register full and the buffer full, with no read emptying them at the edge the third capture arrives. The bench reaches it with three back-to-back capture pulses on one channel. It repeats this for every channel under all sixteen overrun-enable settings. In each pass it reads the time register twice, to show that the first two timestamps survive and the third was dropped. The request line is swept over all 256 values of each mask register while every pending bit is set.

// File: rtl/ccu_irq_pkg.sv
package ccu_irq_pkg;
  localparam int REG_W        = 8;
  localparam int A_PEND0      = 0;
  localparam int A_PEND1      = 1;
  localparam int A_MASK0      = 2;
  localparam int A_MASK1      = 3;
  localparam int A_OVR_EN     = 4;
  localparam int A_TIME_BASE  = 8;
  localparam logic [REG_W-1:0] OVR_EN_RST = 8'hAA;
  localparam int OVR_GRP_BIT  = 4;  // first shared overrun bit in pending-1
endpackage

// File: rtl/ccu_cap_chan.sv
module ccu_cap_chan #(
  parameter int TS_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cap_mode_i,
  input  logic            cap_evt_i,
  input  logic [TS_W-1:0] cap_ts_i,
  input  logic            time_rd_i,
  output logic [TS_W-1:0] time_o,
  output logic            xfer_o,
  output logic            ovr_o
);
  logic            buf_v_q, time_v_q;
  logic [TS_W-1:0] buf_q, time_q;
  logic            cap_ok, load;

  assign cap_ok = cap_mode_i & cap_evt_i;
  // buffer drains when time reg is free or being read this edge
  assign xfer_o = buf_v_q & (~time_v_q | time_rd_i);
  assign ovr_o  = cap_ok & buf_v_q & ~xfer_o;
  assign load   = cap_ok & (~buf_v_q | xfer_o);
  assign time_o = time_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_v_q  <= 1'b0;
      time_v_q <= 1'b0;
      buf_q    <= '0;
      time_q   <= '0;
    end else begin
      if (load)        buf_q <= cap_ts_i;
      if (load)        buf_v_q <= 1'b1;
      else if (xfer_o) buf_v_q <= 1'b0;
      if (xfer_o) begin
        time_q   <= buf_q;
        time_v_q <= 1'b1;
      end else if (time_rd_i) begin
        time_v_q <= 1'b0;
      end
    end
  end

  a_r4_xfer_loads_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |=> (time_v_q && time_q == $past(buf_q)));
  a_r6_ovr_keeps_buf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> (buf_v_q && $stable(buf_q)));
  a_r5_read_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (time_rd_i && !buf_v_q) |=> !time_v_q);
endmodule

// File: rtl/ccu_ovr_merge.sv
module ccu_ovr_merge #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0]   ovr_i,
  input  logic [NUM_CH-1:0]   en_i,
  output logic [NUM_CH/2-1:0] grp_o
);
  localparam int NUM_GRP = NUM_CH / 2;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_o[g] = |(ovr_i[2*g +: 2] & en_i[2*g +: 2]);
  end
endmodule

// File: rtl/ccu_irq_regs.sv
module ccu_irq_regs
  import ccu_irq_pkg::*;
#(
  parameter int               NUM_CH      = 4,
  parameter int               ADDR_W      = 4,
  parameter logic [REG_W-1:0] PEND0_VALID = 8'h3F,
  parameter logic [REG_W-1:0] PEND1_VALID = 8'h30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [REG_W-1:0]  set0_i,
  input  logic [REG_W-1:0]  set1_i,
  output logic [REG_W-1:0]  pend0_o,
  output logic [REG_W-1:0]  pend1_o,
  output logic [NUM_CH-1:0] ovr_en_o,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic [REG_W-1:0]  pend0_q, pend1_q, mask0_q, mask1_q;
  logic [REG_W-1:0]  pend0_d, pend1_d, ovr_en_rd;
  logic [NUM_CH-1:0] ovr_en_q;
  logic              wr_p0, wr_p1, wr_m0, wr_m1, wr_oe;

  assign wr_p0 = wr_en_i && addr_i == ADDR_W'(A_PEND0);
  assign wr_p1 = wr_en_i && addr_i == ADDR_W'(A_PEND1);
  assign wr_m0 = wr_en_i && addr_i == ADDR_W'(A_MASK0);
  assign wr_m1 = wr_en_i && addr_i == ADDR_W'(A_MASK1);
  assign wr_oe = wr_en_i && addr_i == ADDR_W'(A_OVR_EN);

  // writes only clear; a concurrent set wins
  assign pend0_d = (((wr_p0) ? (pend0_q & wdata_i) : pend0_q) | set0_i) & PEND0_VALID;
  assign pend1_d = (((wr_p1) ? (pend1_q & wdata_i) : pend1_q) | set1_i) & PEND1_VALID;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend0_q  <= '0;
      pend1_q  <= '0;
      mask0_q  <= '0;
      mask1_q  <= '0;
      ovr_en_q <= '0;
    end else begin
      pend0_q <= pend0_d;
      pend1_q <= pend1_d;
      if (wr_m0) mask0_q <= wdata_i;
      if (wr_m1) mask1_q <= wdata_i;
      if (wr_oe) begin
        for (int c = 0; c < NUM_CH; c++) ovr_en_q[c] <= wdata_i[2*c];
      end
    end
  end

  always_comb begin
    ovr_en_rd = OVR_EN_RST;
    for (int c = 0; c < NUM_CH; c++) ovr_en_rd[2*c] = ovr_en_q[c];
  end

  always_comb begin
    rdata_o = '0;
    if      (addr_i == ADDR_W'(A_PEND0))  rdata_o = pend0_q;
    else if (addr_i == ADDR_W'(A_PEND1))  rdata_o = pend1_q;
    else if (addr_i == ADDR_W'(A_MASK0))  rdata_o = mask0_q;
    else if (addr_i == ADDR_W'(A_MASK1))  rdata_o = mask1_q;
    else if (addr_i == ADDR_W'(A_OVR_EN)) rdata_o = ovr_en_rd;
  end

  assign irq_o    = (|(pend0_q & mask0_q)) | (|(pend1_q & mask1_q));
  assign pend0_o  = pend0_q;
  assign pend1_o  = pend1_q;
  assign ovr_en_o = ovr_en_q;

  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set0_i != '0) |=> ((pend0_q & $past(set0_i & PEND0_VALID)) == $past(set0_i & PEND0_VALID)));
  a_r9_write_only_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_p0 && set0_i == '0) |=> ((pend0_q & ~$past(pend0_q)) == '0));
  a_r10_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask0_q == '0 && mask1_q == '0) |-> !irq_o);
  a_r7_grp_needs_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_p1 && set1_i == '0) |=> $stable(pend1_q));
endmodule

// File: rtl/ccu_irq_agg.sv
module ccu_irq_agg
  import ccu_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int TS_W   = 16,
  parameter int ADDR_W = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_CH-1:0]            cap_mode_i,
  input  logic [NUM_CH-1:0]            cap_evt_i,
  input  logic [NUM_CH-1:0][TS_W-1:0]  cap_ts_i,
  input  logic [NUM_CH-1:0]            cmp_match_i,
  input  logic [1:0]                   tmr_ovf_i,
  input  logic                         wr_en_i,
  input  logic                         rd_en_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [REG_W-1:0]             wdata_i,
  output logic [TS_W-1:0]              rdata_o,
  output logic [REG_W-1:0]             pend0_o,
  output logic [REG_W-1:0]             pend1_o,
  output logic                         irq_o
);
  localparam int NUM_GRP  = NUM_CH / 2;
  localparam int TMR_BIT  = NUM_CH;
  localparam logic [REG_W-1:0] PEND0_VALID = REG_W'((1 << (NUM_CH + 2)) - 1);
  localparam logic [REG_W-1:0] PEND1_VALID = REG_W'(((1 << NUM_GRP) - 1) << OVR_GRP_BIT);

  logic [NUM_CH-1:0]            time_rd, xfer, ovr, ovr_en, chan_evt;
  logic [NUM_CH-1:0][TS_W-1:0]  time_val;
  logic [NUM_GRP-1:0]           grp_ovr;
  logic [REG_W-1:0]             set0, set1, reg_rdata;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign time_rd[c]  = rd_en_i && addr_i == ADDR_W'(A_TIME_BASE + c);
    assign chan_evt[c] = cap_mode_i[c] ? xfer[c] : cmp_match_i[c];

    ccu_cap_chan #(.TS_W(TS_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cap_mode_i (cap_mode_i[c]),
      .cap_evt_i  (cap_evt_i[c]),
      .cap_ts_i   (cap_ts_i[c]),
      .time_rd_i  (time_rd[c]),
      .time_o     (time_val[c]),
      .xfer_o     (xfer[c]),
      .ovr_o      (ovr[c])
    );
  end

  ccu_ovr_merge #(.NUM_CH(NUM_CH)) u_merge (
    .ovr_i (ovr),
    .en_i  (ovr_en),
    .grp_o (grp_ovr)
  );

  always_comb begin
    set0 = '0;
    set0[NUM_CH-1:0]       = chan_evt;
    set0[TMR_BIT +: 2]     = tmr_ovf_i;
    set1 = '0;
    set1[OVR_GRP_BIT +: NUM_GRP] = grp_ovr;
  end

  ccu_irq_regs #(
    .NUM_CH      (NUM_CH),
    .ADDR_W      (ADDR_W),
    .PEND0_VALID (PEND0_VALID),
    .PEND1_VALID (PEND1_VALID)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .set0_i   (set0),
    .set1_i   (set1),
    .pend0_o  (pend0_o),
    .pend1_o  (pend1_o),
    .ovr_en_o (ovr_en),
    .rdata_o  (reg_rdata),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = TS_W'(reg_rdata);
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == ADDR_W'(A_TIME_BASE + c)) rdata_o = time_val[c];
    end
  end

  a_r2_cmp_sets_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_match_i[0] && !cap_mode_i[0]) |=> pend0_o[0]);
  a_r3_tmr_sets_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_ovf_i[1] |=> pend0_o[TMR_BIT+1]);
endmodule

// File: tb/tb_ccu_irq_agg.sv
module tb_ccu_irq_agg;
  localparam int NUM_CH = 4;
  localparam int TS_W   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NUM_CH-1:0]           cap_mode = '0, cap_evt = '0, cmp_match = '0;
  logic [NUM_CH-1:0][TS_W-1:0] cap_ts = '0;
  logic [1:0]                  tmr_ovf = '0;
  logic                        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]                  addr = '0;
  logic [7:0]                  wdata = '0;
  logic [TS_W-1:0]             rdata;
  logic [7:0]                  pend0, pend1;
  logic                        irq;

  int n_chk = 0, n_fail = 0;
  logic [TS_W-1:0] rv;

  ccu_irq_agg dut (
    .clk_i(clk), .rst_ni(rst_n), .cap_mode_i(cap_mode), .cap_evt_i(cap_evt),
    .cap_ts_i(cap_ts), .cmp_match_i(cmp_match), .tmr_ovf_i(tmr_ovf),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pend0_o(pend0), .pend1_o(pend1), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [3:0] a, output logic [TS_W-1:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(logic [3:0] a, output logic [TS_W-1:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic pulse_cap(int ch, logic [TS_W-1:0] ts);
    @(negedge clk); cap_evt[ch] = 1'b1; cap_ts[ch] = ts;
    @(negedge clk); cap_evt[ch] = 1'b0;
  endtask

  task automatic pulse_cmp(int ch);
    @(negedge clk); cmp_match[ch] = 1'b1;
    @(negedge clk); cmp_match[ch] = 1'b0;
  endtask

  task automatic clear_all();
    bus_wr(4'd0, 8'h00);
    bus_wr(4'd1, 8'h00);
  endtask

  initial begin
    #(8 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(4'd0, rv); check("R1 pend0", rv, 0);
    peek(4'd1, rv); check("R1 pend1", rv, 0);
    peek(4'd2, rv); check("R1 mask0", rv, 0);
    peek(4'd3, rv); check("R1 mask1", rv, 0);
    peek(4'd4, rv); check("R1 ovr_en", rv, 16'h00AA);
    for (int c = 0; c < NUM_CH; c++) begin
      peek(4'(8 + c), rv); check("R1 time", rv, 0);
    end
    check("R1 irq", irq, 0);

    // R2 compare mode, masks zero
    for (int c = 0; c < NUM_CH; c++) begin
      pulse_cmp(c);
      check("R2 cmp pend0", pend0, 32'(1 << c));
      check("R2 cmp irq masked", irq, 0);
      bus_wr(4'd0, 8'h00);
    end
    pulse_cap(0, 16'hBEEF);
    @(negedge clk);
    check("R2 cap ignored pend0", pend0, 0);
    peek(4'd8, rv); check("R2 cap ignored time", rv, 0);

    // R3 timer overflow
    for (int t = 0; t < 2; t++) begin
      @(negedge clk); tmr_ovf[t] = 1'b1;
      @(negedge clk); tmr_ovf[t] = 1'b0;
      check("R3 tmr pend0", pend0, 32'(1 << (4 + t)));
      bus_wr(4'd0, 8'h00);
    end

    // R9 partial clear and set-wins
    @(negedge clk); cmp_match = 4'b0101;
    @(negedge clk); cmp_match = '0;
    bus_wr(4'd0, 8'h04);
    check("R9 partial clear", pend0, 8'h04);
    @(negedge clk); wr_en = 1'b1; addr = 4'd0; wdata = 8'h00; cmp_match[3] = 1'b1;
    @(negedge clk); wr_en = 1'b0; cmp_match[3] = 1'b0;
    check("R9 set wins over clear", pend0, 8'h08);
    bus_wr(4'd0, 8'h00);

    // R8 reserved overrun-enable bits
    bus_wr(4'd4, 8'hFF); peek(4'd4, rv); check("R8 ovr_en ff", rv, 16'h00FF);
    bus_wr(4'd4, 8'h00); peek(4'd4, rv); check("R8 ovr_en 00", rv, 16'h00AA);
    bus_wr(4'd4, 8'h14); peek(4'd4, rv); check("R8 ovr_en 14", rv, 16'h00BE);

    // R4 capture timing, R5 read empties time register
    cap_mode = '1;
    pulse_cap(1, 16'h1234);
    peek(4'd0, rv); check("R4 no pend while buffered", rv, 0);
    @(negedge clk);
    peek(4'd0, rv); check("R4 pend on move", rv, 16'h0002);
    peek(4'd9, rv); check("R4 time value", rv, 16'h1234);
    bus_rd(4'd9, rv); check("R5 read value", rv, 16'h1234);
    bus_wr(4'd0, 8'h00);
    pulse_cap(1, 16'h5678);
    @(negedge clk);
    check("R5 emptied time accepts next", pend0, 8'h02);
    peek(4'd9, rv); check("R5 next time value", rv, 16'h5678);
    bus_rd(4'd9, rv);
    clear_all();

    // R6/R7 overrun sweep over all enable patterns and channels
    for (int en = 0; en < 16; en++) begin
      bus_wr(4'd4, {1'b0, en[3], 1'b0, en[2], 1'b0, en[1], 1'b0, en[0]});
      for (int c = 0; c < NUM_CH; c++) begin
        logic [TS_W-1:0] ts_a, ts_b, ts_c;
        logic [7:0] exp1;
        ts_a = 16'(16'h1000 + en * 16 + c);
        ts_b = 16'(16'h2000 + en * 16 + c);
        ts_c = 16'(16'h3000 + en * 16 + c);
        pulse_cap(c, ts_a);
        pulse_cap(c, ts_b);
        pulse_cap(c, ts_c);
        exp1 = en[c] ? 8'(1 << (4 + c / 2)) : 8'h00;
        check("R7 shared overrun bit", pend1, exp1);
        check("R4 capture pend", pend0, 8'(1 << c));
        bus_rd(4'(8 + c), rv); check("R5 first value held", rv, ts_a);
        check("R5 move on read sets pend", pend0, 8'(1 << c));
        bus_rd(4'(8 + c), rv); check("R6 overrun value dropped", rv, ts_b);
        clear_all();
      end
    end

    // R11 and R10: all sources set, then sweep masks
    bus_wr(4'd4, 8'h55);
    @(negedge clk); cap_evt = '1; cap_ts = '0;
    repeat (3) @(negedge clk);
    cap_evt = '0;
    @(negedge clk); tmr_ovf = 2'b11;
    @(negedge clk); tmr_ovf = 2'b00;
    check("R11 pend0 used bits only", pend0, 8'h3F);
    check("R11 pend1 used bits only", pend1, 8'h30);
    bus_wr(4'd1, 8'hFF);
    check("R11 pend1 after ones write", pend1, 8'h30);
    for (int m = 0; m < 256; m++) begin
      bus_wr(4'd2, 8'(m));
      check("R10 irq mask0 sweep", irq, 32'(|(8'(m) & 8'h3F)));
    end
    bus_wr(4'd2, 8'h00);
    for (int m = 0; m < 256; m++) begin
      bus_wr(4'd3, 8'(m));
      check("R10 irq mask1 sweep", irq, 32'(|(8'(m) & 8'h30)));
    end
    bus_wr(4'd3, 8'h00);
    bus_wr(4'd2, 8'hFF);
    clear_all();
    check("R10 irq low after clear", irq, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule